// File: doc/BRIEF.md
# Interrupt Source Controller with Edge and Level Sources

This block owns a contiguous window of interrupt source numbers, `BASE` up to `BASE+NUM_SRC-1`. Each source is fixed at build time as either message-signalled (edge) or level-signalled. For each source the block holds a destination server, a priority and a parked copy of the priority. Priority 0xFF means masked. Sources raise requests through per-source input lines. The block presents them, one at a time, on a single valid/ready offer stream as a triple of server, global source number and priority.

A presentation controller sits downstream of the offer stream. It sends back three kinds of notice:
- reject, naming a source it refused;
- EOI, naming a source whose service has finished;
- resend, a request to replay what was refused.

The two source kinds follow different rules for these notices:
- Edge sources remember an event that arrives while masked and deliver it when a later configuration write unmasks them.
- Level sources track the line state and a "sent" flag. They offer again only after EOI or after a resend.

A configuration port takes four operations: query, write, park (mask) and restore. The port range-checks the source number and the arguments. It answers one cycle later with a status byte.

Offer stream rules:
- `off_valid` is high while any source has a pending offer.
- Once `off_valid` is high while `off_ready` is low, the offered source number stays the same until a cycle with `off_ready` high completes the transfer.
- Among pending sources, the lowest index goes first.
- The server and priority fields show the source's configuration at the moment of transfer.

Top module: `isc_top`

## Requirements
- R1: Range check. A source number is accepted only if it is at least `BASE` and below `BASE+NUM_SRC`. Any configuration operation naming another number answers status 0xFD (the value -3) and changes nothing. An accepted operation answers 0x00. The response appears with `rsp_valid` one cycle after `cfg_valid`.
- R2: After reset, every source has priority 0xFF, parked priority 0xFF and server 0, and no offer is valid.
- R3: Write validity.
  - A write (op 1) is refused with status 0xFD, leaving the state unchanged, if its priority is above 0xFF or its server is not below `NUM_SERVERS`.
  - An accepted write stores both fields.
  - A query (op 0) returns the stored server and priority.
- R4: Edge source, rising line. If the priority is 0xFF, the event is recorded as masked-pending and no offer is made. Otherwise an offer is made.
- R5: Edge source, configuration write. An offer is made, and masked-pending is cleared, only if masked-pending was set and the new priority is not 0xFF.
- R6: Level source, offer rule. An offer is made when the priority is not 0xFF, the line is high and sent is clear, and making it sets sent. This rule is evaluated on a line change, a configuration write, an EOI and a resend. While sent is set, no further offer is made.
- R7: Reject. A reject notice clears the source's sent flag and sets its rejected flag. No offer follows until a resend.
- R8: Resend, edge sources. An edge source whose rejected flag is set and whose priority is not 0xFF is offered again, and its rejected flag is cleared. A masked rejected edge source stays rejected.
- R9: Resend, level sources. Each level source applies the R6 rule again.
- R10: EOI. On a level source, EOI clears sent and applies the R6 rule again. On an edge source it has no effect.
- R11: Park and restore. Park (op 2) copies the priority into the parked slot, then acts as a write of priority 0xFF. Restore (op 3) acts as a write of the parked priority, with the R5 rule applied.
- R12: Back-pressure. While `off_valid` is high and `off_ready` is low, `off_valid` stays high and `off_num` does not change. Among sources pending together, offers leave in ascending index order.
- R13: Offer payload. `off_num` is `BASE` plus the source index. `off_server` and `off_prio` are that source's configured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_line | input | NUM_SRC | Per-source interrupt lines (edge sources act on rising edge) |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_op | input | 2 | 0 query, 1 write, 2 park, 3 restore |
| cfg_num | input | NUM_W | Global source number |
| cfg_server | input | SRVIN_W | Server for a write |
| cfg_prio | input | 9 | Priority for a write (values above 0xFF are refused) |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_status | output | 8 | 0x00 accepted, 0xFD refused |
| rsp_server | output | SRV_W | Server held after the operation |
| rsp_prio | output | 8 | Priority held after the operation |
| rej_valid | input | 1 | Reject notice strobe |
| rej_num | input | NUM_W | Rejected source number |
| eoi_valid | input | 1 | EOI notice strobe |
| eoi_num | input | NUM_W | Source number being completed |
| resend | input | 1 | Replay request covering all sources |
| off_valid | output | 1 | Offer valid |
| off_ready | input | 1 | Offer accepted by the presentation side |
| off_server | output | SRV_W | Destination server of the offer |
| off_num | output | NUM_W | Global source number of the offer |
| off_prio | output | 8 | Priority of the offer |

## Verification
The bench sweeps every number of a narrow number space through the range check. It also drives both source kinds through the masked, rejected, completed and resent paths.

The main corner cases, and what a wrong design would do in each:
- A masked edge event that is not held would be lost, so the unmasking write would offer nothing.
- A masking write that cleared masked-pending would drop an event that should survive until a real unmask.
- A level source that ignored sent would offer again every cycle its line stays high.
- A resend that cleared the rejected flag of a masked edge source would lose the replay after the later unmask.

Under a stalled offer port, a later pending source with a lower index must not displace the offer already shown. An arbiter without a hold would swap `off_num` in mid-handshake.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {
    OP_QUERY   = 2'd0,
    OP_WRITE   = 2'd1,
    OP_PARK    = 2'd2,
    OP_RESTORE = 2'd3
  } isc_op_e;

  localparam logic [7:0] ST_OK   = 8'h00;
  localparam logic [7:0] ST_ERR  = 8'hFD;
  localparam logic [7:0] PRIO_OFF = 8'hFF;
endpackage

// File: rtl/isc_src_msg.sv
module isc_src_msg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line,
  input  logic [7:0] eff_prio,
  input  logic       wr_en,
  input  logic       rej,
  input  logic       resend,
  input  logic       grant,
  output logic       pend
);
  import isc_pkg::*;
  logic line_q, mpend_q, rejd_q;
  logic pend_n, mpend_n, rejd_n;
  logic masked;

  assign masked = (eff_prio == PRIO_OFF);

  always_comb begin
    pend_n  = pend & ~grant;
    mpend_n = mpend_q;
    rejd_n  = rejd_q | rej;
    if (line && !line_q) begin
      if (masked) mpend_n = 1'b1;
      else        pend_n  = 1'b1;
    end
    if (wr_en && mpend_n && !masked) begin
      pend_n  = 1'b1;
      mpend_n = 1'b0;
    end
    if (resend && rejd_n && !masked) begin
      pend_n = 1'b1;
      rejd_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      mpend_q <= 1'b0;
      rejd_q  <= 1'b0;
      pend    <= 1'b0;
    end else begin
      line_q  <= line;
      mpend_q <= mpend_n;
      rejd_q  <= rejd_n;
      pend    <= pend_n;
    end
  end
endmodule

// File: rtl/isc_src_level.sv
module isc_src_level (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line,
  input  logic [7:0] eff_prio,
  input  logic       wr_en,
  input  logic       rej,
  input  logic       eoi,
  input  logic       resend,
  input  logic       grant,
  output logic       pend
);
  import isc_pkg::*;
  logic asrt_q, sent_q, rejd_q;
  logic pend_n, sent_n, eval;

  assign eval = (line != asrt_q) | wr_en | eoi | resend;

  always_comb begin
    pend_n = pend & ~grant;
    sent_n = sent_q & ~rej & ~eoi;
    if (eval && (eff_prio != PRIO_OFF) && line && !sent_n) begin
      sent_n = 1'b1;
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asrt_q <= 1'b0;
      sent_q <= 1'b0;
      rejd_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      asrt_q <= line;
      sent_q <= sent_n;
      rejd_q <= (rejd_q | rej) & ~resend;
      pend   <= pend_n;
    end
  end
endmodule

// File: rtl/isc_arb.sv
module isc_arb #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] sel
);
  logic             held_q;
  logic [IDX_W-1:0] held_idx_q;
  logic [IDX_W-1:0] first;

  always_comb begin
    first = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend[k]) first = IDX_W'(k);
    end
  end

  assign valid = |pend;
  assign sel   = held_q ? held_idx_q : first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      held_idx_q <= '0;
    end else begin
      held_q     <= valid && !ready;
      held_idx_q <= sel;
    end
  end
endmodule

// File: rtl/isc_top.sv
module isc_top #(
  parameter int NUM_SRC     = 4,
  parameter int BASE        = 8,
  parameter int NUM_SERVERS = 2,
  parameter int NUM_W       = 8,
  parameter int SRVIN_W     = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 4'b1100,
  localparam int SRV_W = (NUM_SERVERS > 1) ? $clog2(NUM_SERVERS) : 1,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_line,
  input  logic               cfg_valid,
  input  logic [1:0]         cfg_op,
  input  logic [NUM_W-1:0]   cfg_num,
  input  logic [SRVIN_W-1:0] cfg_server,
  input  logic [8:0]         cfg_prio,
  output logic               rsp_valid,
  output logic [7:0]         rsp_status,
  output logic [SRV_W-1:0]   rsp_server,
  output logic [7:0]         rsp_prio,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend,
  output logic               off_valid,
  input  logic               off_ready,
  output logic [SRV_W-1:0]   off_server,
  output logic [NUM_W-1:0]   off_num,
  output logic [7:0]         off_prio
);
  import isc_pkg::*;

  localparam logic [NUM_W-1:0] LO_V = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] HI_V = NUM_W'(BASE + NUM_SRC);

  function automatic logic in_win(input logic [NUM_W-1:0] n);
    return (n >= LO_V) && (n < HI_V);
  endfunction

  logic [SRV_W-1:0] srv_q   [NUM_SRC];
  logic [7:0]       prio_q  [NUM_SRC];
  logic [7:0]       saved_q [NUM_SRC];

  isc_op_e          op;
  logic             num_ok, wr_ok, apply;
  logic [IDX_W-1:0] cfg_idx, rej_idx, eoi_idx, sel;
  logic [7:0]       new_prio;
  logic [SRV_W-1:0] new_srv;
  logic             rej_ok, eoi_ok;
  logic [NUM_SRC-1:0] pend, grant;

  assign op      = isc_op_e'(cfg_op);
  assign num_ok  = in_win(cfg_num);
  assign cfg_idx = IDX_W'(cfg_num - LO_V);
  assign rej_idx = IDX_W'(rej_num - LO_V);
  assign eoi_idx = IDX_W'(eoi_num - LO_V);
  assign rej_ok  = rej_valid && in_win(rej_num);
  assign eoi_ok  = eoi_valid && in_win(eoi_num);

  assign wr_ok = (cfg_server < SRVIN_W'(NUM_SERVERS)) && (cfg_prio <= 9'h0FF);

  always_comb begin
    apply    = 1'b0;
    new_prio = prio_q[cfg_idx];
    new_srv  = srv_q[cfg_idx];
    if (cfg_valid && num_ok) begin
      unique case (op)
        OP_WRITE: begin
          apply    = wr_ok;
          new_prio = cfg_prio[7:0];
          new_srv  = SRV_W'(cfg_server);
        end
        OP_PARK: begin
          apply    = 1'b1;
          new_prio = PRIO_OFF;
        end
        OP_RESTORE: begin
          apply    = 1'b1;
          new_prio = saved_q[cfg_idx];
        end
        default: apply = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        srv_q[i]   <= '0;
        prio_q[i]  <= PRIO_OFF;
        saved_q[i] <= PRIO_OFF;
      end
    end else if (apply) begin
      srv_q[cfg_idx]  <= new_srv;
      prio_q[cfg_idx] <= new_prio;
      if (op == OP_PARK) saved_q[cfg_idx] <= prio_q[cfg_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_server <= '0;
      rsp_prio   <= '0;
    end else begin
      rsp_valid <= cfg_valid;
      if (cfg_valid) begin
        rsp_status <= (apply || (num_ok && op == OP_QUERY)) ? ST_OK : ST_ERR;
        rsp_server <= num_ok ? new_srv  : '0;
        rsp_prio   <= num_ok ? new_prio : '0;
      end
    end
  end

  isc_arb #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .ready (off_ready),
    .valid (off_valid),
    .sel   (sel)
  );

  assign off_num    = LO_V + NUM_W'(sel);
  assign off_server = srv_q[sel];
  assign off_prio   = prio_q[sel];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic       wr_g;
    logic [7:0] eff_g;
    assign wr_g     = apply && (cfg_idx == IDX_W'(g));
    assign eff_g    = wr_g ? new_prio : prio_q[g];
    assign grant[g] = off_valid && off_ready && (sel == IDX_W'(g));
    if (LEVEL_MASK[g]) begin : g_lvl
      isc_src_level u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .line     (src_line[g]),
        .eff_prio (eff_g),
        .wr_en    (wr_g),
        .rej      (rej_ok && rej_idx == IDX_W'(g)),
        .eoi      (eoi_ok && eoi_idx == IDX_W'(g)),
        .resend   (resend),
        .grant    (grant[g]),
        .pend     (pend[g])
      );
    end else begin : g_msg
      isc_src_msg u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .line     (src_line[g]),
        .eff_prio (eff_g),
        .wr_en    (wr_g),
        .rej      (rej_ok && rej_idx == IDX_W'(g)),
        .resend   (resend),
        .grant    (grant[g]),
        .pend     (pend[g])
      );
    end
  end
endmodule

// File: rtl/isc_chk.sv
module isc_chk #(
  parameter int NUM_SRC     = 4,
  parameter int BASE        = 8,
  parameter int NUM_SERVERS = 2,
  parameter int NUM_W       = 8,
  parameter int SRV_W       = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic [1:0]       cfg_op,
  input logic [8:0]       cfg_prio,
  input logic             rsp_valid,
  input logic [7:0]       rsp_status,
  input logic             off_valid,
  input logic             off_ready,
  input logic [SRV_W-1:0] off_server,
  input logic [NUM_W-1:0] off_num
);
  // R12: a stalled offer keeps its source number
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid && !off_ready |=> off_valid && $stable(off_num));

  // R13: offered number lies in the window
  a_r13_num_window: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid |-> (off_num >= NUM_W'(BASE)) && (off_num < NUM_W'(BASE + NUM_SRC)));

  // R13: offered server is a legal server
  a_r13_server_legal: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid |-> (int'(off_server) < NUM_SERVERS));

  // R1: only the two status codes appear
  a_r1_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status == 8'h00) || (rsp_status == 8'hFD));

  // R1: response follows a request by one cycle
  a_r1_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> rsp_valid);

  // R3: an out-of-range priority write is refused
  a_r3_prio_refused: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_op == 2'd1 && cfg_prio > 9'h0FF |=> rsp_status == 8'hFD);
endmodule

bind isc_top isc_chk #(
  .NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_SERVERS(NUM_SERVERS),
  .NUM_W(NUM_W), .SRV_W(SRV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
  .cfg_prio(cfg_prio), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .off_valid(off_valid), .off_ready(off_ready), .off_server(off_server),
  .off_num(off_num)
);

// File: tb/sim_isc_top.sv
module sim_isc_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_line = '0;
  logic       cfg_valid = 1'b0;
  logic [1:0] cfg_op = '0;
  logic [7:0] cfg_num = '0;
  logic [7:0] cfg_server = '0;
  logic [8:0] cfg_prio = '0;
  logic       rsp_valid;
  logic [7:0] rsp_status;
  logic [0:0] rsp_server;
  logic [7:0] rsp_prio;
  logic       rej_valid = 1'b0;
  logic [7:0] rej_num = '0;
  logic       eoi_valid = 1'b0;
  logic [7:0] eoi_num = '0;
  logic       resend = 1'b0;
  logic       off_valid;
  logic       off_ready = 1'b0;
  logic [0:0] off_server;
  logic [7:0] off_num;
  logic [7:0] off_prio;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  isc_top u0 (
    .clk(clk), .rst_n(rst_n), .src_line(src_line),
    .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_num(cfg_num),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_server(rsp_server), .rsp_prio(rsp_prio),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend(resend),
    .off_valid(off_valid), .off_ready(off_ready),
    .off_server(off_server), .off_num(off_num), .off_prio(off_prio)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] op, input logic [7:0] num,
                     input logic [7:0] srv, input logic [8:0] pr);
    cfg_valid = 1'b1; cfg_op = op; cfg_num = num; cfg_server = srv; cfg_prio = pr;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic pulse(input int i);
    src_line[i] = 1'b1;
    @(negedge clk);
    src_line[i] = 1'b0;
  endtask

  task automatic take(input string req, input int num, input int srv, input int pr);
    chk({req, " valid"}, int'(off_valid), 1);
    chk({req, " num"}, int'(off_num), num);
    chk({req, " server"}, int'(off_server), srv);
    chk({req, " prio"}, int'(off_prio), pr);
    off_ready = 1'b1;
    @(negedge clk);
    off_ready = 1'b0;
  endtask

  task automatic idle(input string req);
    chk({req, " idle"}, int'(off_valid), 0);
  endtask

  task automatic notice(input int kind, input logic [7:0] num);
    if (kind == 0) begin rej_valid = 1'b1; rej_num = num; end
    else if (kind == 1) begin eoi_valid = 1'b1; eoi_num = num; end
    else resend = 1'b1;
    @(negedge clk);
    rej_valid = 1'b0; eoi_valid = 1'b0; resend = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    idle("R2");
    for (int n = 8; n < 12; n++) begin
      cfg(2'd0, 8'(n), 8'd0, 9'd0);
      chk("R2 prio", int'(rsp_prio), 255);
      chk("R2 server", int'(rsp_server), 0);
    end

    // R1: sweep of the number space
    for (int n = 0; n < 24; n++) begin
      cfg(2'd0, 8'(n), 8'd0, 9'd0);
      chk("R1 valid", int'(rsp_valid), 1);
      chk("R1 status", int'(rsp_status), (n >= 8 && n < 12) ? 8'h00 : 8'hFD);
    end
    cfg(2'd2, 8'd20, 8'd0, 9'd0);
    chk("R1 park range", int'(rsp_status), 8'hFD);

    // R3: refusals and acceptance
    cfg(2'd1, 8'd8, 8'd2, 9'd1);
    chk("R3 server refused", int'(rsp_status), 8'hFD);
    cfg(2'd1, 8'd8, 8'd0, 9'h100);
    chk("R3 prio refused", int'(rsp_status), 8'hFD);
    cfg(2'd0, 8'd8, 8'd0, 9'd0);
    chk("R3 unchanged", int'(rsp_prio), 255);
    cfg(2'd1, 8'd8, 8'd1, 9'd5);
    chk("R3 accepted", int'(rsp_status), 0);
    cfg(2'd0, 8'd8, 8'd0, 9'd0);
    chk("R3 query prio", int'(rsp_prio), 5);
    chk("R3 query server", int'(rsp_server), 1);
    idle("R3");

    // R4: unmasked edge offers at once; masked edge holds
    pulse(0);
    take("R4 R13", 8, 1, 5);
    idle("R4");
    pulse(1);
    idle("R4 masked");
    // R5: unmask releases it
    cfg(2'd1, 8'd9, 8'd0, 9'd7);
    take("R5", 9, 0, 7);
    cfg(2'd1, 8'd9, 8'd0, 9'd6);
    idle("R5 no repeat");
    cfg(2'd1, 8'd9, 8'd0, 9'hFF);
    pulse(1);
    cfg(2'd1, 8'd9, 8'd0, 9'hFF);
    idle("R5 masked write");
    cfg(2'd1, 8'd9, 8'd0, 9'd4);
    take("R5 late", 9, 0, 4);

    // R10: EOI on edge source does nothing
    notice(1, 8'd9);
    idle("R10 edge eoi");

    // R7/R8: reject and resend on edge source
    pulse(1);
    take("R7 first", 9, 0, 4);
    notice(0, 8'd9);
    idle("R7");
    notice(2, 8'd0);
    take("R8 replay", 9, 0, 4);
    notice(2, 8'd0);
    idle("R8 cleared");
    pulse(1);
    take("R8 again", 9, 0, 4);
    notice(0, 8'd9);
    cfg(2'd1, 8'd9, 8'd0, 9'hFF);
    notice(2, 8'd0);
    idle("R8 masked");
    cfg(2'd1, 8'd9, 8'd0, 9'd4);
    idle("R8 no mpend");
    notice(2, 8'd0);
    take("R8 kept", 9, 0, 4);

    // R6/R9/R10: level source
    cfg(2'd1, 8'd10, 8'd1, 9'd3);
    idle("R6 low line");
    src_line[2] = 1'b1;
    @(negedge clk);
    take("R6", 10, 1, 3);
    @(negedge clk);
    idle("R6 sent");
    notice(1, 8'd10);
    take("R10 level eoi", 10, 1, 3);
    notice(0, 8'd10);
    idle("R7 level");
    @(negedge clk);
    idle("R7 level wait");
    notice(2, 8'd0);
    take("R9", 10, 1, 3);
    src_line[2] = 1'b0;
    @(negedge clk);
    notice(1, 8'd10);
    idle("R10 low");

    src_line[3] = 1'b1;
    @(negedge clk);
    idle("R6 masked");
    cfg(2'd1, 8'd11, 8'd0, 9'd2);
    take("R6 write", 11, 0, 2);
    src_line[3] = 1'b0;
    @(negedge clk);
    notice(1, 8'd11);
    idle("R6 low");

    // R12: ordering under stall
    cfg(2'd1, 8'd8, 8'd1, 9'd1);
    cfg(2'd1, 8'd9, 8'd0, 9'd1);
    src_line = 4'b1111;
    @(negedge clk);
    src_line[1:0] = 2'b00;
    for (int k = 0; k < 3; k++) begin
      chk("R12 hold", int'(off_num), 8);
      @(negedge clk);
    end
    take("R12 o0", 8, 1, 1);
    take("R12 o1", 9, 0, 1);
    take("R12 o2", 10, 1, 3);
    take("R12 o3", 11, 0, 2);
    idle("R12 drained");
    src_line = '0;
    @(negedge clk);
    notice(1, 8'd10);
    notice(1, 8'd11);
    pulse(1);
    chk("R12 shown", int'(off_num), 9);
    pulse(0);
    chk("R12 no swap", int'(off_num), 9);
    take("R12 held", 9, 0, 1);
    take("R12 next", 8, 1, 1);

    // R11: park and restore
    cfg(2'd2, 8'd8, 8'd0, 9'd0);
    chk("R11 park", int'(rsp_status), 0);
    chk("R11 park prio", int'(rsp_prio), 255);
    pulse(0);
    idle("R11 parked");
    cfg(2'd3, 8'd8, 8'd0, 9'd0);
    chk("R11 restore prio", int'(rsp_prio), 1);
    take("R11 release", 8, 1, 1);
    idle("R11 end");

    done = 1;
    summary();
  end
endmodule